// File: doc/BRIEF.md
# Row-Enable Pattern Register for Cascaded Sampling Rows

This block drives the input-enable lines of a group of sampling-array rows (four by default). Every row has one enable bit. While sampling runs, a row captures its input only when its bit is set. The contents of a small pattern register decide how the rows are used. With every bit set, each row runs all the time as its own channel. With a single bit set, the pattern moves one row onward each time the write pointer completes a full turn of the sampling ring. The rows then fill one after another and act as a single channel with four times the depth.

The block counts write-cell ticks and finds the wrap from the last cell back to cell 0. On each wrap it rotates the pattern by one position. When sampling is stopped, the pattern can be written in parallel or shifted in serially, one bit per cycle. A serial output carries the bit of the last row. With chain mode enabled, the first row takes its new bit from the serial input at each rotation instead of from the local last row. Several devices can then be daisy-chained into one very deep channel. The current pattern is always available for readback.

Top module: `rowcasc_top`

## Requirements
- R1: After reset the pattern is all ones, `rowEn` is zero (sampling stopped), and `serOut` is 1.
- R2: While `sampleEn` is 1, `rowEn[i]` equals pattern bit i. While `sampleEn` is 0, `rowEn` is all zeros.
- R3: With `sampleEn` 0, a cycle with `loadEn` 1 writes `loadPattern` into the pattern. The new value is visible on the outputs after that clock edge.
- R4: With `sampleEn` 1, `loadEn` has no effect on the pattern.
- R5: With `sampleEn` 0 and `shiftEn` 1, the pattern becomes {pattern[N-2:0], serIn}, and `serOut` always shows pattern bit N-1. If `loadEn` is also 1, the load wins and no shift takes place.
- R6: A turn of the ring is NUM_CELLS `cellTick` pulses taken while `sampleEn` is 1. Ticks while stopped are not counted, and the cell position is kept across a stop.
- R7: On the tick that wraps the ring from the last cell to cell 0, bit i moves to bit i+1. With `chainMode` 0, bit N-1 returns to bit 0.
- R8: With `chainMode` 1, bit 0 takes `serIn` at the rotation instead of the old bit N-1.
- R9: The pattern 1111 stays unchanged across turns (four channels). The pattern 0001 enables rows 0,1,2,3,0,... on successive turns (one deep channel).
- R10: `patternOut` always equals the current pattern register.
- R11: With `sampleEn` 1, `shiftEn` has no effect on the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sampling running (1) or stopped (0) |
| cellTick | input | 1 | Write pointer advanced by one cell |
| loadEn | input | 1 | Parallel load request (honoured only when stopped) |
| loadPattern | input | NUM_ROWS | Pattern value for a parallel load, bit i = row i |
| shiftEn | input | 1 | Serial shift request (honoured only when stopped) |
| serIn | input | 1 | Serial input: shift data, and chain feedback in chain mode |
| chainMode | input | 1 | 1 selects `serIn` as the rotation feedback source |
| rowEn | output | NUM_ROWS | Input-enable line for each row |
| serOut | output | 1 | Bit of the last row, for the next device in a chain |
| patternOut | output | NUM_ROWS | Current pattern, for readback |

## Verification
The bench checks where the rotation falls. A design that rotates one tick early or late, or that counts ticks taken while stopped, moves the active row at the wrong cycle. It also checks that loads and shifts are locked out while sampling. Without that lockout, the single active row of a deep channel would be corrupted in the middle of a capture. The bench compares chain feedback with local circulation: a design with the feedback mux reversed loses the circulating bit or duplicates it. It also confirms that load takes priority over a simultaneous shift.

// File: rtl/rowcasc_pkg.sv
package rowcasc_pkg;

  // Strobes from the control to the pattern datapath; at most one is high.
  typedef struct packed {
    logic loadPar;   // parallel write of the pattern
    logic shiftSer;  // serial shift-in of one bit
    logic rotate;    // ring wrapped: advance the pattern by one row
  } patStrobe_t;

endpackage

// File: rtl/rowcasc_ctrl.sv
module rowcasc_ctrl
  import rowcasc_pkg::*;
#(
  parameter int NUM_CELLS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       cellTick,
  input  logic       loadEn,
  input  logic       shiftEn,
  output patStrobe_t strobes
);

  localparam int CNT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;
  localparam logic [CNT_W-1:0] LAST_CELL = CNT_W'(NUM_CELLS - 1);

  logic [CNT_W-1:0] cellCnt;
  logic             lastCell;
  logic             tickTaken;

  always_comb begin
    lastCell  = (cellCnt == LAST_CELL);
    tickTaken = sampleEn && cellTick;
  end

  // Write-pointer position within the ring; frozen while sampling is stopped.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellCnt <= '0;
    end else if (tickTaken) begin
      if (lastCell) cellCnt <= '0;
      else          cellCnt <= cellCnt + 1'b1;
    end
  end

  // Loads and shifts are accepted only while stopped; load beats shift.
  always_comb begin
    strobes          = '0;
    strobes.loadPar  = loadEn && !sampleEn;
    strobes.shiftSer = shiftEn && !sampleEn && !loadEn;
    strobes.rotate   = tickTaken && lastCell;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cellCnt <= LAST_CELL); // R6
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(cellCnt)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)); // R5

endmodule

// File: rtl/rowcasc_path.sv
module rowcasc_path
  import rowcasc_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter logic [NUM_ROWS-1:0] RESET_PATTERN = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  patStrobe_t          strobes,
  input  logic [NUM_ROWS-1:0] loadVal,
  input  logic                serIn,
  input  logic                chainMode,
  output logic [NUM_ROWS-1:0] patQ
);

  localparam int TOP = NUM_ROWS - 1;

  logic                feedBit;
  logic [NUM_ROWS-1:0] patD;

  always_comb begin
    feedBit = chainMode ? serIn : patQ[TOP];
    patD    = patQ;
    if (strobes.loadPar)       patD = loadVal;
    else if (strobes.shiftSer) patD = {patQ[TOP-1:0], serIn};
    else if (strobes.rotate)   patD = {patQ[TOP-1:0], feedBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) patQ <= RESET_PATTERN;
    else       patQ <= patD;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(patQ)); // R4
  AST_ROTATE_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rotate |=> (patQ[TOP:1] == $past(patQ[TOP-1:0]))); // R7
  AST_CIRCULATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rotate && !chainMode) |=> ($countones(patQ) == $countones($past(patQ)))); // R7
  AST_CHAIN_FEED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rotate && chainMode) |=> (patQ[0] == $past(serIn))); // R8
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftSer |=> (patQ[0] == $past(serIn))); // R5

endmodule

// File: rtl/rowcasc_top.sv
module rowcasc_top
  import rowcasc_pkg::*;
#(
  parameter int NUM_ROWS  = 4,
  parameter int NUM_CELLS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleEn,
  input  logic                cellTick,
  input  logic                loadEn,
  input  logic [NUM_ROWS-1:0] loadPattern,
  input  logic                shiftEn,
  input  logic                serIn,
  input  logic                chainMode,
  output logic [NUM_ROWS-1:0] rowEn,
  output logic                serOut,
  output logic [NUM_ROWS-1:0] patternOut
);

  patStrobe_t          strobes;
  logic [NUM_ROWS-1:0] patQ;

  rowcasc_ctrl #(.NUM_CELLS(NUM_CELLS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .cellTick (cellTick),
    .loadEn   (loadEn),
    .shiftEn  (shiftEn),
    .strobes  (strobes)
  );

  rowcasc_path #(.NUM_ROWS(NUM_ROWS), .RESET_PATTERN('1)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadVal   (loadPattern),
    .serIn     (serIn),
    .chainMode (chainMode),
    .patQ      (patQ)
  );

  always_comb begin
    rowEn      = sampleEn ? patQ : '0;
    serOut     = patQ[NUM_ROWS-1];
    patternOut = patQ;
  end

  AST_NO_WRITE_SAMPLING: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && !cellTick) |=> $stable(patternOut)); // R11
  AST_SEROUT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serOut) |-> $past(patQ[NUM_ROWS-2]) || strobes == '0 || $past(strobes.loadPar)); // R5

endmodule

// File: tb/test_rowcasc_top.sv
module test_rowcasc_top;

  localparam int ROWS  = 4;
  localparam int CELLS = 32;

  typedef struct {
    string           tag;
    logic [ROWS-1:0] pat;
    logic [ROWS-1:0] row;
    logic            so;
  } item_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sampleEn = 1'b0;
  logic            cellTick = 1'b0;
  logic            loadEn = 1'b0;
  logic [ROWS-1:0] loadPattern = '0;
  logic            shiftEn = 1'b0;
  logic            serIn = 1'b0;
  logic            chainMode = 1'b0;
  logic [ROWS-1:0] rowEn;
  logic            serOut;
  logic [ROWS-1:0] patternOut;

  item_t           sbQ[$];
  int              checks = 0;
  int              errors = 0;
  bit              done = 1'b0;
  logic [ROWS-1:0] mPat = '1;
  int              mCnt = 0;

  always #5 clk = ~clk;

  rowcasc_top #(.NUM_ROWS(ROWS), .NUM_CELLS(CELLS)) i_rowcasc_top (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .cellTick(cellTick),
    .loadEn(loadEn), .loadPattern(loadPattern), .shiftEn(shiftEn),
    .serIn(serIn), .chainMode(chainMode), .rowEn(rowEn), .serOut(serOut),
    .patternOut(patternOut)
  );

  // Driver: applies one cycle of inputs and predicts the state after the edge.
  task automatic cyc(input logic s, input logic t, input logic l, input logic [ROWS-1:0] lv,
                     input logic sh, input logic si, input logic ch, input string tag);
    item_t it;
    sampleEn = s; cellTick = t; loadEn = l; loadPattern = lv;
    shiftEn = sh; serIn = si; chainMode = ch;
    if (l && !s) begin
      mPat = lv;
    end else if (sh && !s) begin
      mPat = {mPat[ROWS-2:0], si};
    end else if (s && t) begin
      if (mCnt == CELLS - 1) begin
        mCnt = 0;
        mPat = {mPat[ROWS-2:0], (ch ? si : mPat[ROWS-1])};
      end else begin
        mCnt = mCnt + 1;
      end
    end
    it.tag = tag;
    it.pat = mPat;
    it.row = s ? mPat : '0;
    it.so  = mPat[ROWS-1];
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares outputs shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (patternOut !== it.pat || rowEn !== it.row || serOut !== it.so) begin
          errors++;
          $display("FAIL %s: pattern=%b rowEn=%b serOut=%b, expected pattern=%b rowEn=%b serOut=%b",
                   it.tag, patternOut, rowEn, serOut, it.pat, it.row, it.so);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state visible before any write
    cyc(0, 0, 0, '0, 0, 0, 0, "R1");
    // R9 / R2: all-ones pattern across two turns, four channels
    for (int i = 0; i < 2 * CELLS; i++) cyc(1, 1, 0, '0, 0, 0, 0, "R9");
    cyc(1, 0, 0, '0, 0, 0, 0, "R2");
    // R3: parallel load when stopped, then R2 dark rows while stopped
    cyc(0, 0, 1, 4'b0001, 0, 0, 0, "R3");
    cyc(0, 0, 0, '0, 0, 0, 0, "R2");
    // R7 / R9: single bit walks rows 0..3..0, tick every cycle
    for (int i = 0; i < 5 * CELLS; i++) cyc(1, 1, 0, '0, 0, 0, 0, "R7");
    // R6: sparse ticks, then ticks while stopped must not count
    for (int i = 0; i < 2 * CELLS + 6; i++) cyc(1, (i % 2 == 0), 0, '0, 0, 0, 0, "R6");
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, '0, 0, 0, 0, "R6");
    for (int i = 0; i < 2 * CELLS; i++) cyc(1, 1, 0, '0, 0, 0, 0, "R6");
    // R4 / R11: load and shift during sampling are ignored
    cyc(1, 0, 1, 4'b1010, 0, 0, 0, "R4");
    cyc(1, 0, 0, '0, 1, 1, 0, "R11");
    cyc(1, 0, 1, 4'b0110, 1, 0, 0, "R4");
    // R5: serial shift while stopped, serOut follows the last row
    cyc(0, 0, 1, 4'b0000, 0, 0, 0, "R3");
    cyc(0, 0, 0, '0, 1, 1, 0, "R5");
    cyc(0, 0, 0, '0, 1, 0, 0, "R5");
    cyc(0, 0, 0, '0, 1, 1, 0, "R5");
    cyc(0, 0, 0, '0, 1, 1, 0, "R5");
    cyc(0, 0, 0, '0, 1, 0, 0, "R5");
    cyc(0, 0, 1, 4'b0100, 1, 1, 0, "R5");
    cyc(0, 0, 0, '0, 0, 0, 0, "R10");
    // R8: chain feedback from serIn at the wrap
    cyc(0, 0, 1, 4'b1000, 0, 0, 0, "R3");
    for (int i = 0; i < 2 * CELLS; i++) cyc(1, 1, 0, '0, 0, 0, 1, "R8");
    for (int i = 0; i < 2 * CELLS; i++) cyc(1, 1, 0, '0, 0, 1, 1, "R8");
    // R9: restore four channels and confirm they hold
    cyc(0, 0, 1, 4'b1111, 0, 0, 0, "R3");
    for (int i = 0; i < CELLS + 2; i++) cyc(1, 1, 0, '0, 0, 0, 0, "R9");
    cyc(0, 0, 0, '0, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule